// File: doc/BRIEF.md
# Priority Push-Button and Footswitch Event Capture

This block turns already-debounced button and footswitch levels into discrete events for a processor that polls them on a slow service tick. Each push button built into a rotary encoder is watched for the moment it goes down. Presses are latched until the next service tick. On that tick the highest-numbered pending button is reported as a binary code with a one-clock valid strobe, and every other pending press is discarded along with it. The design assumes a person rarely presses two buttons within one service interval (8 periods of a 48 kHz audio rate, about 167 µs), so it needs only one reporting slot.

The four footswitch inputs are handled differently. They are active-low, and all of them are watched in parallel. Each one that is grounded raises its own sticky event flag, and the flag stays set until the consumer clears it by writing a one to the matching acknowledge bit. Footswitch events therefore never compete with each other or with the buttons. All inputs pass through a two-flop synchronizer before edge detection.

Top module: `btn_evt_capture`

## Requirements
- R1: A button event is latched only when a button level goes from 0 (released) to 1 (pressed). Holding a button down creates no further event, and neither does releasing it.
- R2: When a service tick finds more than one button event pending, the reported code is the binary index of the highest-numbered pending button, with bit 0 of the level input being index 0.
- R3: Servicing one button event clears every pending button event at the same time. A lower-numbered press that was pending alongside the reported one is lost.
- R4: The valid output goes high for exactly one clock, in the cycle after a service tick that found an event pending. It stays low when there is no tick or nothing is pending. The code output holds its value until the next serviced event.
- R5: A footswitch input going from 1 to 0 sets the event flag of the same bit. Bit 0 is auto-calibrate, bit 1 is mute, bit 2 is preset up and bit 3 is preset down. Simultaneous falls on several inputs set all of their flags.
- R6: An event flag stays set until a 1 is written on the same bit of the acknowledge input. A footswitch that stays grounded, or that is released, sets no flag again. If a new fall and an acknowledge arrive in the same cycle, the new fall wins.
- R7: After reset, the valid output is 0, the code output is 0 and every flag is 0. Each input reaches the edge detector two clocks after it changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_lvl_i | input | NUM_BTN | Debounced button levels, 1 = pressed |
| gpio_n_i | input | NUM_GPIO | Debounced footswitch levels, 0 = grounded/active |
| svc_tick_i | input | 1 | Service tick; one button event is reported per tick |
| gpio_ack_i | input | NUM_GPIO | Write-one-to-clear acknowledge for the flags |
| btn_code_o | output | IDX_W | Index of the reported button |
| btn_valid_o | output | 1 | One-clock strobe marking a new button code |
| gpio_evt_o | output | NUM_GPIO | Sticky footswitch event flags |

## Verification
The hardest case to reach from the ports is two presses that land inside one service interval, where the lower press has to vanish instead of being reported on the next tick. The stimulus presses two or more buttons in the same window, then services once. It then holds the same levels and services again, expecting no strobe, which shows that the dropped press was cleared and not merely postponed. A press that arrives while no tick comes is held for many cycles so that the strobe can be seen to wait for the tick. Footswitch inputs are kept grounded across an acknowledge to show that a held level does not set the flag again.

// File: rtl/btn_evt_pkg.sv
// Package: shared names for the button/footswitch event capture block.
// Assumes footswitch bit positions are fixed by the consumer's decoding.
package btn_evt_pkg;

    // Footswitch bit positions in gpio_n_i / gpio_evt_o / gpio_ack_i
    typedef enum int {
        FSW_AUTOCAL   = 0,
        FSW_MUTE      = 1,
        FSW_PRESET_UP = 2,
        FSW_PRESET_DN = 3
    } fsw_bit_e;

    localparam int FSW_COUNT = 4;

endpackage

// File: rtl/evt_sync2.sv
// Module: two-flop synchronizer for a vector of slow, debounced levels.
// Assumes each bit changes slowly enough that bits need no coherence.
// RESET_VAL gives the idle level so that no false edge appears after reset.
module evt_sync2 #(
    parameter int              WIDTH     = 4,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage capture of the incoming levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/btn_evt_arbiter.sv
// Module: latches button press edges and reports the highest pending one
// per service tick, clearing all pending presses when it does.
// Assumes synchronized levels with 1 = pressed.
module btn_evt_arbiter #(
    parameter int NUM_BTN = 8,
    parameter int IDX_W   = (NUM_BTN > 1) ? $clog2(NUM_BTN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] lvl_s,
    input  logic               svc_tick,
    output logic [IDX_W-1:0]   code_o,
    output logic               valid_o
);

    localparam logic [NUM_BTN-1:0] ONE_HOT_LSB = {{(NUM_BTN-1){1'b0}}, 1'b1};

    logic [NUM_BTN-1:0] prev_q;
    logic [NUM_BTN-1:0] pend_q;
    logic [NUM_BTN-1:0] press;
    logic [IDX_W-1:0]   sel_idx;
    logic [IDX_W-1:0]   code_q;
    logic               valid_q;
    logic               pend_any;

    // Rising edge of each button level marks a press
    assign press    = lvl_s & ~prev_q;
    assign pend_any = |pend_q;

    // Priority encoder: the last set bit scanned upward is the highest index
    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM_BTN; i++) begin
            if (pend_q[i]) sel_idx = IDX_W'(i);
        end
    end

    // Edge history, pending set, and report on the service tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pend_q  <= '0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            prev_q  <= lvl_s;
            valid_q <= 1'b0;
            if (svc_tick && pend_any) begin
                code_q  <= sel_idx;
                valid_q <= 1'b1;
                pend_q  <= press;
            end else begin
                pend_q  <= pend_q | press;
            end
        end
    end

    assign code_o  = code_q;
    assign valid_o = valid_q;

    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(svc_tick)); // R4
    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(code_q)); // R4
    AST_CODE_IS_TOP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (($past(pend_q) >> code_q) == ONE_HOT_LSB)); // R2
    AST_PEND_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(press)) == '0)); // R1

endmodule

// File: rtl/gpio_evt_flags.sv
// Module: parallel falling-edge capture for active-low footswitch inputs
// with sticky write-one-to-clear flags. A new edge beats a same-cycle ack.
// Assumes synchronized levels with 0 = grounded/active.
module gpio_evt_flags #(
    parameter int NUM_GPIO = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GPIO-1:0] lvl_n_s,
    input  logic [NUM_GPIO-1:0] ack_i,
    output logic [NUM_GPIO-1:0] flag_o
);

    logic [NUM_GPIO-1:0] prev_n_q;
    logic [NUM_GPIO-1:0] flag_q;
    logic [NUM_GPIO-1:0] fall;

    // A 1-to-0 step on an input is an activation
    assign fall = prev_n_q & ~lvl_n_s;

    // Edge history and sticky flags with clear-on-ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_n_q <= '1;
            flag_q   <= '0;
        end else begin
            prev_n_q <= lvl_n_s;
            flag_q   <= (flag_q & ~ack_i) | fall;
        end
    end

    assign flag_o = flag_q;

    AST_FLAG_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(fall)) == '0)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~ack_i) != '0) |=> ((flag_q & $past(flag_q & ~ack_i)) == $past(flag_q & ~ack_i))); // R6

endmodule

// File: rtl/btn_evt_capture.sv
// Module: top of the button/footswitch event capture block.
// Synchronizes both input groups, then feeds the priority button
// arbiter and the parallel footswitch flag bank.
// Assumes the inputs are already debounced.
module btn_evt_capture #(
    parameter int NUM_BTN  = 8,
    parameter int NUM_GPIO = btn_evt_pkg::FSW_COUNT,
    parameter int IDX_W    = (NUM_BTN > 1) ? $clog2(NUM_BTN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BTN-1:0]  btn_lvl_i,
    input  logic [NUM_GPIO-1:0] gpio_n_i,
    input  logic                svc_tick_i,
    input  logic [NUM_GPIO-1:0] gpio_ack_i,
    output logic [IDX_W-1:0]    btn_code_o,
    output logic                btn_valid_o,
    output logic [NUM_GPIO-1:0] gpio_evt_o
);

    logic [NUM_BTN-1:0]  btn_s;
    logic [NUM_GPIO-1:0] gpio_n_s;

    evt_sync2 #(.WIDTH(NUM_BTN), .RESET_VAL('0)) i_btn_sync (
        .clk(clk), .rst_n(rst_n), .async_i(btn_lvl_i), .sync_o(btn_s)
    );

    evt_sync2 #(.WIDTH(NUM_GPIO), .RESET_VAL('1)) i_gpio_sync (
        .clk(clk), .rst_n(rst_n), .async_i(gpio_n_i), .sync_o(gpio_n_s)
    );

    btn_evt_arbiter #(.NUM_BTN(NUM_BTN), .IDX_W(IDX_W)) i_arb (
        .clk(clk), .rst_n(rst_n), .lvl_s(btn_s), .svc_tick(svc_tick_i),
        .code_o(btn_code_o), .valid_o(btn_valid_o)
    );

    gpio_evt_flags #(.NUM_GPIO(NUM_GPIO)) i_flags (
        .clk(clk), .rst_n(rst_n), .lvl_n_s(gpio_n_s), .ack_i(gpio_ack_i),
        .flag_o(gpio_evt_o)
    );

    AST_VALID_NEEDS_TICK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        btn_valid_o |-> $past(svc_tick_i)); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!btn_valid_o && gpio_evt_o == '0)); // R7

endmodule

// File: tb/test_btn_evt_capture.sv
// Bench: vector table for button sequences, then directed footswitch,
// reset and no-tick cases.
module test_btn_evt_capture;
    import btn_evt_pkg::*;

    localparam int NB = 8;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] btn_lvl = '0;
    logic [NG-1:0] gpio_n = '1;
    logic          tick = 1'b0;
    logic [NG-1:0] ack = '0;
    logic [2:0]    code;
    logic          valid;
    logic [NG-1:0] evt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    btn_evt_capture i_btn_evt_capture (
        .clk(clk), .rst_n(rst_n), .btn_lvl_i(btn_lvl), .gpio_n_i(gpio_n),
        .svc_tick_i(tick), .gpio_ack_i(ack), .btn_code_o(code),
        .btn_valid_o(valid), .gpio_evt_o(evt)
    );

    // {levels[7:0], expect_valid, expect_code[2:0]}
    localparam logic [11:0] VEC [9] = '{
        {8'b0000_0001, 1'b1, 3'd0},  // R1 single press
        {8'b0000_0001, 1'b0, 3'd0},  // R1 held: no event
        {8'b0000_0000, 1'b0, 3'd0},  // R1 release: no event
        {8'b0010_0100, 1'b1, 3'd5},  // R2 two presses, top wins
        {8'b0010_0100, 1'b0, 3'd5},  // R3 lower press was cleared
        {8'b0000_0000, 1'b0, 3'd5},
        {8'b1000_0010, 1'b1, 3'd7},  // R2 top button
        {8'b1000_0000, 1'b0, 3'd7},  // R1 release of bit 1
        {8'b1000_1000, 1'b1, 3'd3}   // R2 only new press reported
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic service(string req, logic ev, logic [2:0] ec);
        tick = 1'b1;
        step();
        check(req, 32'(valid), 32'(ev));
        check(req, 32'(code), 32'(ec));
        tick = 1'b0;
        step();
        check("R4 one-cycle strobe", 32'(valid), 32'd0);
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        wait_n(3);
        check("R7 reset valid", 32'(valid), 32'd0);
        check("R7 reset code", 32'(code), 32'd0);
        check("R7 reset flags", 32'(evt), 32'd0);
        rst_n = 1'b1;
        wait_n(3);
        check("R7 idle flags", 32'(evt), 32'd0);

        for (int v = 0; v < 9; v++) begin
            btn_lvl = VEC[v][11:4];
            wait_n(4);
            service($sformatf("R1/R2/R3 vector %0d", v), VEC[v][3], VEC[v][2:0]);
        end

        // R4: a press without a tick is held, not strobed
        btn_lvl = 8'b1001_1000;
        wait_n(10);
        check("R4 no tick no valid", 32'(valid), 32'd0);
        check("R4 code holds", 32'(code), 32'd3);
        service("R4 pending served on tick", 1'b1, 3'd4);
        service("R4 tick with nothing pending", 1'b0, 3'd4);

        // R5: parallel falls on auto-calibrate and preset up
        gpio_n = 4'b1111;
        gpio_n[FSW_AUTOCAL] = 1'b0;
        gpio_n[FSW_PRESET_UP] = 1'b0;
        wait_n(4);
        check("R5 two flags", 32'(evt), 32'b0101);

        // R6: ack clears, held low does not set again
        ack[FSW_AUTOCAL] = 1'b1;
        step();
        ack = '0;
        check("R6 ack clears bit0", 32'(evt), 32'b0100);
        wait_n(6);
        check("R6 held low no re-set", 32'(evt), 32'b0100);
        gpio_n = 4'b1111;
        wait_n(5);
        check("R6 release sets nothing", 32'(evt), 32'b0100);
        ack = 4'b1111;
        step();
        ack = '0;
        check("R6 ack all", 32'(evt), 32'b0000);

        // R5: all four at once
        gpio_n = 4'b0000;
        wait_n(4);
        check("R5 all four flags", 32'(evt), 32'b1111);

        // R6: new fall beats same-cycle ack on mute
        gpio_n = 4'b1111;
        wait_n(4);
        ack = 4'b1111;
        step();
        ack = '0;
        gpio_n[FSW_MUTE] = 1'b0;
        step();
        step();
        ack[FSW_MUTE] = 1'b1;
        step();
        ack = '0;
        check("R6 fall beats ack", 32'(evt), 32'b0010);

        // R7: reset clears flags mid-run
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R7 reset clears flags", 32'(evt), 32'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule